// File: doc/BRIEF.md
# Proof-of-Work Search Control Register Bank

This block is the software-facing side of a hash-based proof-of-work search engine. A processor on a Wishbone bus loads a 256-bit block header, a 256-bit target and a 64-bit starting nonce. It sets run, test and halt flags, and picks the two padding bytes the hash core appends to its message. The bank presents all of this to the engine as plain configuration outputs. In the other direction it observes the engine's running and found indications, and captures the winning nonce.

The bank owns the interrupt line. A found report from the engine latches the nonce and raises the interrupt. The interrupt stays high until software reads the control word. A read-only identification word lets software confirm that the block is present. Everything runs on one clock. Reset is asynchronous and active high.

The bus side is a single-beat target. A request is a cycle in which both stb and cyc are high. The bank answers each request with one ack pulse and never stalls. The master keeps its request until it sees ack, then drops stb or cyc before it issues the next request.

Top module: `pow_csr_bank`

## Requirements
- R1: While reset is high and after it is released, ack and irq are low and rdat is zero. Header, target and start nonce read zero. All control flags are low, the trailing pad byte is 0x80 and the leading pad byte is 0x06.
- R2: ack goes high for exactly one cycle, in the cycle after the first rising edge at which stb and cyc are both high. It does not rise again until stb or cyc has been low at a clock edge.
- R3: The word index is adr[6:2] and the other address bits are ignored. Words 4..11 form the header, 12..19 the target and 20..21 the start nonce. In each multi-word value the lower index holds the less significant 32 bits.
- R4: A write stores byte lane k, which is bits 8k+7:8k, only when sel[k] is high. The other bytes of the word are unchanged.
- R5: Writes to words 0..3 and to indexes 23..31 change nothing. Reads of indexes 23..31 return zero.
- R6: Word 3 always reads 0x53484133, the ASCII text "SHA3" with the first character in the top byte.
- R7: Control word 22 holds the run flag in bit 0, the test flag in bit 1, the halt flag in bit 2, the trailing pad byte in bits 23:16 and the leading pad byte in bits 31:24. Its other bits read zero.
- R8: Status word 2 reads {29'b0, test flag, eng_running, found flag}. The found flag is the same state as irq.
- R9: A cycle with eng_found high stores eng_nonce into word 0 (low half) and word 1 (high half) and sets irq, both at the next clock edge.
- R10: A read of word 22 clears irq at the edge that raises its ack. If eng_found is high at that same edge, irq stays set.
- R11: While ack is high after a read, rdat holds the word as it was just before the acking edge. At all other times, including write acks, rdat is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_stb | input | 1 | Wishbone strobe |
| bus_cyc | input | 1 | Wishbone cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 4 | Byte lane enables |
| bus_adr | input | 32 | Byte address |
| bus_wdat | input | 32 | Write data |
| bus_ack | output | 1 | Transfer acknowledge |
| bus_rdat | output | 32 | Read data |
| eng_found | input | 1 | Engine reports a qualifying nonce |
| eng_running | input | 1 | Engine is stepping nonces |
| eng_nonce | input | 64 | Nonce that met the target |
| cfg_header | output | 256 | Block header to the engine |
| cfg_target | output | 256 | Target value to the engine |
| cfg_start | output | 64 | Starting nonce |
| cfg_run | output | 1 | Run flag |
| cfg_test | output | 1 | Test flag (exact-match mode) |
| cfg_halt | output | 1 | Halt flag |
| cfg_pad_last | output | 8 | Trailing pad byte |
| cfg_pad_first | output | 8 | Leading pad byte |
| irq | output | 1 | Solution interrupt |

## Verification
On every cycle the assertions check the following:
- the ack pulse is one cycle wide;
- rdat is zero outside a read ack;
- the identification word reads correctly;
- a found report always leads to irq;
- irq only falls after a control-word read request.

The bench's scenarios are needed for the rest:
- byte-lane merging and little-endian word order into the configuration outputs;
- read-only and unmapped words ignoring writes;
- a held strobe drawing only one ack;
- the edge where a found report and a control read collide.

A behavioural model tracks each of these cycle by cycle.

// File: rtl/pow_csr_pkg.sv
package pow_csr_pkg;
  localparam int WORD_W    = 32;
  localparam int LANES     = WORD_W / 8;
  localparam int IDX_W     = 5;
  localparam int SOL_IDX   = 0;
  localparam int STAT_IDX  = 2;
  localparam int ID_IDX    = 3;
  localparam int HDR_IDX   = 4;
  localparam int HDR_N     = 8;
  localparam int TGT_IDX   = HDR_IDX + HDR_N;
  localparam int TGT_N     = 8;
  localparam int START_IDX = TGT_IDX + TGT_N;
  localparam int START_N   = 2;
  localparam int CTL_IDX   = START_IDX + START_N;
  localparam int RW_FIRST  = HDR_IDX;
  localparam int RW_COUNT  = CTL_IDX - HDR_IDX + 1;

  localparam logic [WORD_W-1:0] ID_WORD   = 32'h5348_4133;
  localparam logic [WORD_W-1:0] CTL_MASK  = 32'hFFFF_0007;
  localparam logic [WORD_W-1:0] CTL_RESET = 32'h0680_0000;

  typedef struct packed {
    logic       run;
    logic       test;
    logic       halt;
    logic [7:0] pad_last;
    logic [7:0] pad_first;
  } ctl_t;

  function automatic logic [WORD_W-1:0] word_reset(input int idx);
    return (idx == CTL_IDX) ? CTL_RESET : '0;
  endfunction

  function automatic logic [WORD_W-1:0] word_mask(input int idx);
    return (idx == CTL_IDX) ? CTL_MASK : '1;
  endfunction

  function automatic ctl_t unpack_ctl(input logic [WORD_W-1:0] w);
    ctl_t c;
    c.run       = w[0];
    c.test      = w[1];
    c.halt      = w[2];
    c.pad_last  = w[23:16];
    c.pad_first = w[31:24];
    return c;
  endfunction
endpackage

// File: rtl/pow_csr_bus.sv
module pow_csr_bus
  import pow_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             cyc,
  input  logic             we,
  input  logic [31:0]      adr,
  output logic             ack,
  output logic             acc_rd,
  output logic             acc_wr,
  output logic [IDX_W-1:0] idx
);
  logic req, served_q, acc;

  assign req    = stb & cyc;
  assign acc    = req & ~ack & ~served_q;
  assign acc_rd = acc & ~we;
  assign acc_wr = acc & we;
  assign idx    = adr[IDX_W+1:2];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ack      <= 1'b0;
      served_q <= 1'b0;
    end else begin
      ack      <= acc;
      served_q <= req & (served_q | ack);
    end
  end
endmodule

// File: rtl/pow_csr_store.sv
module pow_csr_store
  import pow_csr_pkg::*;
#(
  parameter int FIRST = RW_FIRST,
  parameter int COUNT = RW_COUNT
)(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [LANES-1:0]             wr_sel,
  input  logic [WORD_W-1:0]            wr_data,
  output logic [COUNT-1:0][WORD_W-1:0] words
);
  for (genvar w = 0; w < COUNT; w++) begin : g_word
    localparam logic [WORD_W-1:0] RV = word_reset(FIRST + w);
    localparam logic [WORD_W-1:0] MK = word_mask(FIRST + w);
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(FIRST + w));
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or posedge rst) begin
        if (rst)
          words[w][8*b +: 8] <= RV[8*b +: 8];
        else if (hit && wr_sel[b])
          words[w][8*b +: 8] <= wr_data[8*b +: 8] & MK[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/pow_csr_irq.sv
module pow_csr_irq #(
  parameter int NONCE_W = 64
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               found,
  input  logic [NONCE_W-1:0] nonce,
  input  logic               clr,
  output logic               irq,
  output logic [NONCE_W-1:0] sol
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      irq <= 1'b0;
      sol <= '0;
    end else begin
      if (found) begin
        irq <= 1'b1;
        sol <= nonce;
      end else if (clr) begin
        irq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pow_csr_bank.sv
module pow_csr_bank
  import pow_csr_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_stb,
  input  logic         bus_cyc,
  input  logic         bus_we,
  input  logic [3:0]   bus_sel,
  input  logic [31:0]  bus_adr,
  input  logic [31:0]  bus_wdat,
  output logic         bus_ack,
  output logic [31:0]  bus_rdat,
  input  logic         eng_found,
  input  logic         eng_running,
  input  logic [63:0]  eng_nonce,
  output logic [255:0] cfg_header,
  output logic [255:0] cfg_target,
  output logic [63:0]  cfg_start,
  output logic         cfg_run,
  output logic         cfg_test,
  output logic         cfg_halt,
  output logic [7:0]   cfg_pad_last,
  output logic [7:0]   cfg_pad_first,
  output logic         irq
);
  logic                            acc_rd, acc_wr;
  logic [IDX_W-1:0]                idx;
  logic [RW_COUNT-1:0][WORD_W-1:0] rw;
  logic [63:0]                     sol;
  logic [WORD_W-1:0]               rd_word;
  ctl_t                            ctl;

  pow_csr_bus u_bus (
    .clk(clk), .rst(rst), .stb(bus_stb), .cyc(bus_cyc), .we(bus_we),
    .adr(bus_adr), .ack(bus_ack), .acc_rd(acc_rd), .acc_wr(acc_wr), .idx(idx)
  );

  pow_csr_store #(.FIRST(RW_FIRST), .COUNT(RW_COUNT)) u_store (
    .clk(clk), .rst(rst), .wr_en(acc_wr), .wr_idx(idx), .wr_sel(bus_sel),
    .wr_data(bus_wdat), .words(rw)
  );

  pow_csr_irq #(.NONCE_W(64)) u_irq (
    .clk(clk), .rst(rst), .found(eng_found), .nonce(eng_nonce),
    .clr(acc_rd && (idx == IDX_W'(CTL_IDX))), .irq(irq), .sol(sol)
  );

  assign ctl           = unpack_ctl(rw[CTL_IDX-RW_FIRST]);
  assign cfg_header    = rw[HDR_IDX-RW_FIRST +: HDR_N];
  assign cfg_target    = rw[TGT_IDX-RW_FIRST +: TGT_N];
  assign cfg_start     = rw[START_IDX-RW_FIRST +: START_N];
  assign cfg_run       = ctl.run;
  assign cfg_test      = ctl.test;
  assign cfg_halt      = ctl.halt;
  assign cfg_pad_last  = ctl.pad_last;
  assign cfg_pad_first = ctl.pad_first;

  always_comb begin
    rd_word = '0;
    if (idx == IDX_W'(SOL_IDX))       rd_word = sol[31:0];
    if (idx == IDX_W'(SOL_IDX + 1))   rd_word = sol[63:32];
    if (idx == IDX_W'(STAT_IDX))      rd_word = {29'b0, ctl.test, eng_running, irq};
    if (idx == IDX_W'(ID_IDX))        rd_word = ID_WORD;
    for (int k = 0; k < RW_COUNT; k++)
      if (idx == IDX_W'(RW_FIRST + k)) rd_word = rw[k];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) bus_rdat <= '0;
    else     bus_rdat <= acc_rd ? rd_word : '0;
  end
endmodule

// File: rtl/pow_csr_bank_chk.sv
module pow_csr_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_stb,
  input logic        bus_cyc,
  input logic        bus_we,
  input logic [31:0] bus_adr,
  input logic        bus_ack,
  input logic [31:0] bus_rdat,
  input logic        eng_found,
  input logic        irq
);
  a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  a_r2_ack_after_req: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack) |-> $past(bus_stb && bus_cyc));

  a_r11_rdat_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_ack |-> bus_rdat == 32'h0);

  a_r6_id_word: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && $past(!bus_we && bus_adr[6:2] == 5'd3)) |-> bus_rdat == 32'h5348_4133);

  a_r9_found_raises_irq: assert property (@(posedge clk) disable iff (rst)
    eng_found |=> irq);

  a_r10_irq_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(bus_stb && bus_cyc && !bus_we && bus_adr[6:2] == 5'd22));
endmodule

bind pow_csr_bank pow_csr_bank_chk u_chk (.*);

// File: tb/pow_csr_bank_tb.sv
module pow_csr_bank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_stb = 0, bus_cyc = 0, bus_we = 0;
  logic [3:0] bus_sel = 4'hF;
  logic [31:0] bus_adr = 0, bus_wdat = 0;
  logic bus_ack;
  logic [31:0] bus_rdat;
  logic eng_found = 0, eng_running = 0;
  logic [63:0] eng_nonce = 0;
  logic [255:0] cfg_header, cfg_target;
  logic [63:0] cfg_start;
  logic cfg_run, cfg_test, cfg_halt, irq;
  logic [7:0] cfg_pad_last, cfg_pad_first;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pow_csr_bank u_dut (.*);

  // behavioural reference model
  logic [31:0] m_mem [0:22];
  logic [63:0] m_sol;
  logic m_irq, m_ack, m_served;
  logic [31:0] m_rdat;

  function automatic logic [31:0] m_read(input int i);
    if (i == 0) return m_sol[31:0];
    if (i == 1) return m_sol[63:32];
    if (i == 2) return {29'b0, m_mem[22][1], eng_running, m_irq};
    if (i == 3) return 32'h5348_4133;
    if (i >= 4 && i <= 22) return m_mem[i];
    return 32'h0;
  endfunction

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < 23; i++) m_mem[i] = 32'h0;
      m_mem[22] = 32'h0680_0000;
      m_sol = 0; m_irq = 0; m_ack = 0; m_served = 0; m_rdat = 0;
    end else begin
      automatic bit req = bus_stb && bus_cyc;
      automatic bit acc = req && !m_ack && !m_served;
      automatic int i = int'(bus_adr[6:2]);
      automatic logic [31:0] rd = m_read(i);
      m_served = req && (m_served || m_ack);
      m_ack = acc;
      m_rdat = (acc && !bus_we) ? rd : 32'h0;
      if (acc && bus_we && i >= 4 && i <= 22)
        for (int b = 0; b < 4; b++)
          if (bus_sel[b]) m_mem[i][8*b +: 8] = bus_wdat[8*b +: 8];
      m_mem[22] &= 32'hFFFF_0007;
      if (eng_found) begin
        m_irq = 1; m_sol = eng_nonce;
      end else if (acc && !bus_we && i == 22) m_irq = 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] m_vec8(input int base);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = m_mem[base + k];
    return v;
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 ack", 64'(bus_ack), 64'(m_ack));
      chk("R11 rdat", 64'(bus_rdat), 64'(m_rdat));
      chk("R10 irq", 64'(irq), 64'(m_irq));
      chk("R3 header", 64'(cfg_header == m_vec8(4)), 64'd1);
      chk("R3 target", 64'(cfg_target == m_vec8(12)), 64'd1);
      chk("R3 start", cfg_start, {m_mem[21], m_mem[20]});
      chk("R7 ctl", {cfg_pad_first, cfg_pad_last, 13'b0, cfg_halt, cfg_test, cfg_run},
          64'(m_mem[22]));
    end
  end

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_stb = 1; bus_cyc = 1; bus_we = 1; bus_adr = a; bus_wdat = d; bus_sel = s;
    do @(negedge clk); while (!bus_ack);
    bus_stb = 0; bus_cyc = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_stb = 1; bus_cyc = 1; bus_we = 0; bus_adr = a;
    do @(negedge clk); while (!bus_ack);
    d = bus_rdat;
    bus_stb = 0; bus_cyc = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    int acks;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ack", 64'(bus_ack), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 rdat", 64'(bus_rdat), 0);
    chk("R1 pads", {cfg_pad_first, cfg_pad_last}, 64'h0680);
    chk("R1 flags", {cfg_run, cfg_test, cfg_halt}, 0);
    chk("R1 header", 64'(cfg_header == 0), 1);
    rst = 0;
    @(negedge clk);

    // R6 identification word
    bus_rd(32'd3 << 2, d);
    chk("R6 id", d, 64'h5348_4133);
    // R3 upper address bits ignored
    bus_rd(32'h1000_0000 | (32'd3 << 2), d);
    chk("R3 upper adr", d, 64'h5348_4133);

    // R3 header / target / start, little-endian words
    for (int k = 0; k < 8; k++) bus_wr(32'(4 + k) << 2, 32'hA000_0000 + 32'(k), 4'hF);
    chk("R3 header lsw", cfg_header[31:0], 64'hA000_0000);
    chk("R3 header msw", cfg_header[255:224], 64'hA000_0007);
    bus_wr(32'd20 << 2, 32'h1111_2222, 4'hF);
    bus_wr(32'd21 << 2, 32'h3333_4444, 4'hF);
    chk("R3 start", cfg_start, 64'h3333_4444_1111_2222);

    // R4 byte lanes
    bus_wr(32'd12 << 2, 32'h0, 4'hF);
    bus_wr(32'd12 << 2, 32'hAABB_CCDD, 4'b0101);
    bus_rd(32'd12 << 2, d);
    chk("R4 lanes", d, 64'h00BB_00DD);
    bus_wr(32'd12 << 2, 32'h1200_0000, 4'b1000);
    chk("R4 lane3", cfg_target[31:0], 64'h12BB_00DD);

    // R5 read-only and unmapped
    bus_wr(32'd0, 32'hFFFF_FFFF, 4'hF);
    bus_wr(32'd3 << 2, 32'h0, 4'hF);
    bus_wr(32'd25 << 2, 32'hDEAD_BEEF, 4'hF);
    bus_rd(32'd0, d);
    chk("R5 sol ro", d, 0);
    bus_rd(32'd3 << 2, d);
    chk("R5 id ro", d, 64'h5348_4133);
    bus_rd(32'd25 << 2, d);
    chk("R5 unmapped", d, 0);

    // R7 control layout
    bus_wr(32'd22 << 2, 32'hFFFF_FFFF, 4'hF);
    bus_rd(32'd22 << 2, d);
    chk("R7 ctl mask", d, 64'hFFFF_0007);
    bus_wr(32'd22 << 2, 32'h0180_0002, 4'hF);
    chk("R7 fields", {cfg_pad_first, cfg_pad_last, 5'b0, cfg_halt, cfg_test, cfg_run},
        64'h0180_02);

    // R8 status
    eng_running = 1;
    bus_rd(32'd2 << 2, d);
    chk("R8 status", d, 64'h6);

    // R9 found latches nonce
    @(negedge clk); eng_nonce = 64'h1122_3344_5566_7788; eng_found = 1;
    @(negedge clk); eng_found = 0; eng_nonce = 0;
    chk("R9 irq", 64'(irq), 1);
    bus_rd(32'd0, d);
    chk("R9 sol lo", d, 64'h5566_7788);
    bus_rd(32'd1 << 2, d);
    chk("R9 sol hi", d, 64'h1122_3344);
    bus_rd(32'd2 << 2, d);
    chk("R8 found bit", d, 64'h7);

    // R10 control read clears irq
    bus_rd(32'd22 << 2, d);
    chk("R10 cleared", 64'(irq), 0);

    // R10 found at the same edge as a control read
    @(negedge clk);
    bus_stb = 1; bus_cyc = 1; bus_we = 0; bus_adr = 32'd22 << 2;
    eng_found = 1; eng_nonce = 64'h99;
    @(negedge clk);
    eng_found = 0;
    chk("R10 collide ack", 64'(bus_ack), 1);
    chk("R10 collide irq", 64'(irq), 1);
    bus_stb = 0; bus_cyc = 0;
    bus_rd(32'd22 << 2, d);
    chk("R10 later clear", 64'(irq), 0);

    // R2 held strobe gets one ack
    @(negedge clk);
    bus_stb = 1; bus_cyc = 1; bus_we = 0; bus_adr = 32'd3 << 2;
    acks = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (bus_ack) acks++;
    end
    bus_stb = 0; bus_cyc = 0;
    chk("R2 single ack", 64'(acks), 1);
    // R11 write ack carries zero data
    @(negedge clk);
    bus_stb = 1; bus_cyc = 1; bus_we = 1; bus_adr = 32'd4 << 2; bus_wdat = 32'h5;
    @(negedge clk);
    chk("R11 write rdat", 64'(bus_rdat), 0);
    bus_stb = 0; bus_cyc = 0; bus_we = 0;
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule